// File: doc/BRIEF.md
# Multi-Line Hit Stream Merger

This block collects hit data from a group of front-end readout chips. Each chip shifts its data out on one or two serial lines, and the block receives one bit per line per clock. Each line has its own receiver. The receiver searches for the 20-bit framing pattern at any bit offset and declares the line locked once the pattern has repeated at a steady alignment. From then on the receiver cuts the bit stream into 20-bit words. Framing words are discarded. Hit words are pushed into a small FIFO for that line.

A round-robin arbiter drains the line FIFOs, one word per clock. Each word leaves as a registered parallel word: the 16-bit hit payload, then the 6-bit identifier of the chip that produced it. The payload holds a 3-bit ADC value (bits 15:13), a 7-bit strip number (bits 12:6) and a 6-bit beam-crossing counter (bits 5:0). The block passes the payload through unchanged. A 6-bit identifier covers the 52 chips of two detector wedges.

Top module: `hit_stream_merger`

## Requirements
- R1: Every line is deserialized on its own, most significant bit first, into 20-bit words. The payload of a forwarded hit word equals the low 16 bits of the received word.
- R2: A line asserts its `line_locked` bit after four consecutive framing words (default pattern 20'h3F1C5) are received at one bit alignment. The alignment may sit at any bit offset. After only three framing words the bit stays low.
- R3: Words received while a line is not locked are never forwarded. This includes a hit word that interrupts an incomplete lock sequence.
- R4: Framing words are removed and never appear on the output.
- R5: A locked word whose top nibble is 4'hA is a hit. It is forwarded as `{payload[15:0], chip_id[5:0]}`, where chip_id = CHIP_BASE + line_index / LINES_PER_CHIP.
- R6: A locked word that is neither a framing word nor a hit is a framing error. A single error leaves the line locked. Two errors in a row clear `line_locked`, and hits are dropped until the line locks again.
- R7: Words from one line leave the block in the order that line received them.
- R8: At most one word leaves per clock. When several lines hold words, they are served in cyclic round-robin order, starting with the line after the one served last.
- R9: A hit that arrives at a full line FIFO is dropped, and that line's `line_ovf` bit is set. The bit stays set until reset, and the bits of other lines are unaffected.
- R10: After reset, `out_valid`, `line_locked` and `line_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | N_LINES | One serial data bit per line per clock |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | 22 | Hit payload (bits 21:6) and chip identifier (bits 5:0) |
| line_locked | output | N_LINES | Per-line framing lock |
| line_ovf | output | N_LINES | Per-line sticky FIFO overflow flag |

## Verification
The hardest condition to reach is a line FIFO overflow. The output drains one word per clock, while each line delivers at most one word every 20 clocks. Overflow therefore needs more than 20 busy lines. The bench instantiates 24 lines with 4-entry FIFOs and keeps 23 of them streaming hits until the backlog exceeds the storage. While words are being dropped, it checks that each line's output is still an in-order subsequence of what that line sent. It also checks that the silent line never raises its flag. Lock at a non-zero bit offset is reached by shifting a few idle bits ahead of the framing words.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int WORD_W = 20;
  localparam int PAY_W  = 16;
  localparam int ID_W   = 6;
  localparam int TAG_W  = WORD_W - PAY_W;

  typedef enum logic [1:0] {
    RX_SEARCH = 2'd0,
    RX_ALIGN  = 2'd1,
    RX_LOCKED = 2'd2
  } rx_state_e;
endpackage

// File: rtl/hsm_line_rx.sv
module hsm_line_rx
  import hsm_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_PAT  = 20'h3F1C5,
  parameter logic [TAG_W-1:0]  HIT_TAG   = 4'hA,
  parameter int                LOCK_CNT  = 4,
  parameter int                ERR_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic             word_vld,
  output logic [PAY_W-1:0] word_pay,
  output logic             locked
);
  localparam int BC_W = $clog2(WORD_W);
  localparam int SC_W = $clog2(LOCK_CNT + 1);
  localparam int EC_W = $clog2(ERR_LIMIT + 1);

  rx_state_e         st;
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] nxt_sr;
  logic [BC_W-1:0]   bitcnt;
  logic [SC_W-1:0]   syncs;
  logic [EC_W-1:0]   errs;
  logic              at_bound, is_sync, is_hit;

  always_comb begin
    nxt_sr   = {sr[WORD_W-2:0], din};
    at_bound = (bitcnt == BC_W'(WORD_W - 1));
    is_sync  = (nxt_sr == SYNC_PAT);
    is_hit   = (nxt_sr[WORD_W-1:PAY_W] == HIT_TAG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_SEARCH;
      sr       <= '0;
      bitcnt   <= '0;
      syncs    <= '0;
      errs     <= '0;
      word_vld <= 1'b0;
      word_pay <= '0;
    end else begin
      sr       <= nxt_sr;
      word_vld <= 1'b0;
      case (st)
        RX_SEARCH: begin
          if (is_sync) begin
            st     <= RX_ALIGN;
            syncs  <= SC_W'(1);
            bitcnt <= '0;
          end
        end
        RX_ALIGN: begin
          if (at_bound) begin
            bitcnt <= '0;
            if (!is_sync) begin
              st <= RX_SEARCH;
            end else if (syncs == SC_W'(LOCK_CNT - 1)) begin
              st   <= RX_LOCKED;
              errs <= '0;
            end else begin
              syncs <= syncs + SC_W'(1);
            end
          end else begin
            bitcnt <= bitcnt + BC_W'(1);
          end
        end
        RX_LOCKED: begin
          if (at_bound) begin
            bitcnt <= '0;
            if (is_sync) begin
              errs <= '0;
            end else if (is_hit) begin
              word_vld <= 1'b1;
              word_pay <= nxt_sr[PAY_W-1:0];
              errs     <= '0;
            end else if (errs == EC_W'(ERR_LIMIT - 1)) begin
              st   <= RX_SEARCH;
              errs <= '0;
            end else begin
              errs <= errs + EC_W'(1);
            end
          end else begin
            bitcnt <= bitcnt + BC_W'(1);
          end
        end
        default: st <= RX_SEARCH;
      endcase
    end
  end

  assign locked = (st == RX_LOCKED);

  // R3
  push_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(st) == RX_LOCKED);

  // R4
  hit_only_push_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> ($past(nxt_sr[WORD_W-1:PAY_W]) == HIT_TAG));

  // R2
  lock_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(bitcnt) == BC_W'(WORD_W - 1));
endmodule

// File: rtl/hsm_line_fifo.sv
module hsm_line_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, do_wr, do_rd;

  always_comb begin
    full  = (cnt == CW'(DEPTH));
    empty = (cnt == '0);
    do_wr = wr_en && !full;
    do_rd = rd_en && !empty;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + AW'(1);
      if (do_rd) rptr <= rptr + AW'(1);
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R8
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/hsm_rr_arb.sv
module hsm_rr_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] last;

  always_comb begin
    any   = |req;
    gidx  = last;
    grant = '0;
    for (int k = N; k >= 1; k--) begin
      if (req[(int'(last) + k) % N]) gidx = IW'((int'(last) + k) % N);
    end
    if (any) grant[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IW'(N - 1);
    else if (any) last <= gidx;
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/hit_stream_merger.sv
module hit_stream_merger
  import hsm_pkg::*;
#(
  parameter int                N_LINES        = 4,
  parameter int                LINES_PER_CHIP = 1,
  parameter int                CHIP_BASE      = 0,
  parameter int                FIFO_DEPTH     = 16,
  parameter int                LOCK_CNT       = 4,
  parameter int                ERR_LIMIT      = 2,
  parameter logic [WORD_W-1:0] SYNC_PAT       = 20'h3F1C5,
  parameter logic [TAG_W-1:0]  HIT_TAG        = 4'hA
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_LINES-1:0]      ser_in,
  output logic                    out_valid,
  output logic [PAY_W+ID_W-1:0]   out_data,
  output logic [N_LINES-1:0]      line_locked,
  output logic [N_LINES-1:0]      line_ovf
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] wvld, empty, grant;
  logic [PAY_W-1:0]   wpay  [N_LINES];
  logic [PAY_W-1:0]   fifo_q[N_LINES];
  logic [IW-1:0]      gidx;
  logic               any;
  logic [ID_W-1:0]    cid;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    hsm_line_rx #(
      .SYNC_PAT (SYNC_PAT),
      .HIT_TAG  (HIT_TAG),
      .LOCK_CNT (LOCK_CNT),
      .ERR_LIMIT(ERR_LIMIT)
    ) u_rx (
      .clk     (clk),
      .rst     (rst),
      .din     (ser_in[i]),
      .word_vld(wvld[i]),
      .word_pay(wpay[i]),
      .locked  (line_locked[i])
    );

    hsm_line_fifo #(
      .DEPTH(FIFO_DEPTH),
      .W    (PAY_W)
    ) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wvld[i]),
      .wr_data(wpay[i]),
      .rd_en  (grant[i]),
      .rd_data(fifo_q[i]),
      .empty  (empty[i]),
      .ovf    (line_ovf[i])
    );
  end

  hsm_rr_arb #(
    .N (N_LINES),
    .IW(IW)
  ) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (~empty),
    .grant(grant),
    .gidx (gidx),
    .any  (any)
  );

  always_comb cid = ID_W'(CHIP_BASE + (int'(gidx) / LINES_PER_CHIP));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= any;
      if (any) out_data <= {fifo_q[gidx], cid};
    end
  end
endmodule

// File: tb/tb_hit_stream_merger.sv
module tb_hit_stream_merger;
  localparam int N    = 24;
  localparam int LPC  = 2;
  localparam int BASE = 3;
  localparam int DEP  = 4;
  localparam logic [19:0] SYNC = 20'h3F1C5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ser = '0;
  logic         out_valid;
  logic [21:0]  out_data;
  logic [N-1:0] line_locked, line_ovf;

  always #2 clk = ~clk;

  hit_stream_merger #(
    .N_LINES(N), .LINES_PER_CHIP(LPC), .CHIP_BASE(BASE), .FIFO_DEPTH(DEP)
  ) dut (
    .clk(clk), .rst(rst), .ser_in(ser), .out_valid(out_valid),
    .out_data(out_data), .line_locked(line_locked), .line_ovf(line_ovf)
  );

  int n_chk = 0, n_err = 0, n_out = 0, hseq = 0;
  bit tolerant = 0;
  logic [15:0] expq [N][$];
  int seq_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: strip field (payload bits 12:6) carries the line index
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      automatic logic [15:0] p = out_data[21:6];
      automatic int l = int'(p[12:6]);
      n_out++;
      seq_q.push_back(l);
      if (l >= N) chk(0, "R1", "line index", l, 0);
      else begin
        chk(int'(out_data[5:0]) == BASE + l / LPC, "R5", "chip id",
            out_data[5:0], BASE + l / LPC);
        if (tolerant) begin
          while (expq[l].size() > 0 && expq[l][0] != p) void'(expq[l].pop_front());
          chk(expq[l].size() > 0, "R7", "subsequence order", p, 0);
          if (expq[l].size() > 0) void'(expq[l].pop_front());
        end else if (expq[l].size() == 0) begin
          chk(0, "R3", "unexpected word", p, 0);
        end else begin
          chk(expq[l][0] == p, "R7", "payload/order", p, expq[l][0]);
          void'(expq[l].pop_front());
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    ser = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int l = 0; l < N; l++) expq[l].delete();
    seq_q.delete();
    n_out = 0;
    tolerant = 0;
  endtask

  task automatic send_words(input logic [19:0] w [N]);
    for (int b = 19; b >= 0; b--) begin
      for (int l = 0; l < N; l++) ser[l] = w[l][b];
      @(negedge clk);
    end
  endtask

  task automatic send_sync(input int times);
    logic [19:0] w [N];
    for (int l = 0; l < N; l++) w[l] = SYNC;
    repeat (times) send_words(w);
  endtask

  task automatic send_hits(input logic [N-1:0] mask, input bit expect_out);
    logic [19:0] w [N];
    for (int l = 0; l < N; l++) begin
      automatic logic [15:0] p = {3'(hseq + l), 7'(l), 6'(hseq)};
      w[l] = mask[l] ? {4'hA, p} : SYNC;
      if (mask[l] && expect_out) expq[l].push_back(p);
    end
    hseq++;
    send_words(w);
  endtask

  task automatic send_bad(input logic [N-1:0] mask);
    logic [19:0] w [N];
    for (int l = 0; l < N; l++) w[l] = mask[l] ? 20'h51234 : SYNC;
    send_words(w);
  endtask

  task automatic drain_check(input string req);
    int left = 0;
    send_sync(4);
    for (int l = 0; l < N; l++) left += expq[l].size();
    chk(left == 0, req, "words missing after drain", left, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
    chk(line_locked == '0, "R10", "line_locked", line_locked, 0);
    chk(line_ovf == '0, "R10", "line_ovf", line_ovf, 0);
  endtask

  task automatic t_lock_offset();
    do_reset();
    repeat (7) @(negedge clk);
    send_sync(3);
    chk(line_locked == '0, "R2", "locked after 3 syncs", line_locked, 0);
    send_sync(1);
    chk(line_locked == '1, "R2", "locked after 4 syncs", line_locked, {N{1'b1}});
    send_hits('1, 1);
    send_hits(24'h00F0F3, 1);
    drain_check("R1");
    chk(n_out == N + 10, "R1", "output count", n_out, N + 10);
  endtask

  task automatic t_partial_lock();
    do_reset();
    send_sync(3);
    send_hits('1, 0);
    chk(line_locked == '0, "R3", "no lock after broken sequence", line_locked, 0);
    send_sync(4);
    chk(line_locked == '1, "R3", "relock", line_locked, {N{1'b1}});
    send_hits(24'h000101, 1);
    drain_check("R3");
    chk(n_out == 2, "R3", "only post-lock hits out", n_out, 2);
  endtask

  task automatic t_sync_strip();
    do_reset();
    send_sync(4);
    send_hits(24'h800001, 1);
    send_sync(2);
    send_hits(24'h800001, 1);
    send_sync(1);
    drain_check("R4");
    chk(n_out == 4, "R4", "syncs removed", n_out, 4);
  endtask

  task automatic t_framing();
    do_reset();
    send_sync(4);
    send_bad(24'h1);
    chk(line_locked[0] == 1'b1, "R6", "one error keeps lock", line_locked[0], 1);
    send_hits(24'h1, 1);
    send_bad(24'h1);
    send_bad(24'h1);
    chk(line_locked[0] == 1'b0, "R6", "two errors unlock", line_locked[0], 0);
    chk(line_locked[N-1:1] == '1, "R6", "other lines locked", line_locked[N-1:1], {(N-1){1'b1}});
    send_hits(24'h1, 0);
    send_sync(4);
    chk(line_locked[0] == 1'b1, "R6", "relock", line_locked[0], 1);
    send_hits(24'h1, 1);
    drain_check("R6");
    chk(n_out == 2, "R6", "hits while unlocked dropped", n_out, 2);
  endtask

  task automatic t_round_robin();
    int bad = 0;
    do_reset();
    send_sync(4);
    send_hits('1, 1);
    drain_check("R8");
    chk(seq_q.size() == N, "R8", "one word per line", seq_q.size(), N);
    for (int i = 1; i < seq_q.size(); i++)
      if (seq_q[i] != (seq_q[i-1] + 1) % N) bad++;
    chk(bad == 0, "R8", "cyclic grant order breaks", bad, 0);
  endtask

  task automatic t_overflow();
    logic [N-1:0] m = '1;
    m[5] = 1'b0;
    do_reset();
    send_sync(4);
    chk(line_ovf == '0, "R9", "flags before burst", line_ovf, 0);
    tolerant = 1;
    repeat (60) send_hits(m, 1);
    chk(line_ovf != '0, "R9", "overflow flagged", line_ovf, 1);
    chk(line_ovf[5] == 1'b0, "R9", "idle line flag", line_ovf[5], 0);
    send_sync(6);
    chk(line_ovf != '0, "R9", "flag sticky", line_ovf, 1);
    do_reset();
    chk(line_ovf == '0, "R9", "flags cleared by reset", line_ovf, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lock_offset();
    t_partial_lock();
    t_sync_strip();
    t_framing();
    t_round_robin();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule